// File: doc/BRIEF.md
# Disk Controller Command Sequencer

This block sequences commands through a single byte-wide data port. Software writes an opcode byte and its parameter bytes into the port. The sequencer decodes the low five bits of the first byte to learn how many bytes the command takes. Once the final byte arrives, it passes the whole command to an execution unit with a one-cycle start pulse. When the execution unit signals completion, the sequencer presents the result bytes one at a time on the same port.

A main status byte tells software which way the port is facing and whether it is ready:

- bit 7: ready for a transfer
- bit 6: direction (1 means the controller is talking to the CPU)
- bit 5: non-DMA mode
- bit 4: command in progress
- bits 3:0: per-drive seek-busy flags, passed through from the drive side

Two commands answer without using the execution unit. The version query returns a fixed byte. An unknown opcode returns a fixed "invalid command" byte.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset, with drive_busy at zero, the status byte is 80h, exec_start is 0 and rd_data is 00h.
- R2: The number of bytes collected depends on the low five bits of the first byte.
  - 9 bytes: opcodes 00110, 01100, 00101, 01001, 00010, 10001, 11001, 11101.
  - 6 bytes: 01101.
  - 3 bytes: 00011 and 01111.
  - 2 bytes: 01010, 00111 and 00100.
  - 1 byte: 01000, 10000 and any other code.

  For every code except 10000 and the unknown ones, exec_start is high in the cycle after the final byte is accepted. In that cycle exec_op equals the five opcode bits and exec_cmd holds byte k at bits [8k+7:8k].
- R3: Status bit 4 is high from the first accepted byte until the command fully ends. While execution is awaited, bit 7 and bit 6 are 0.
- R4: Opcodes in the 9-byte group, 01010 and 01101 return seven result bytes after exec_done. Byte k is exec_res[8k+7:8k]: ST0, ST1, ST2, cylinder, head, sector, size code.
- R5: Opcodes 00011, 01111 and 00111 have no result phase. The status byte shows ready with direction 0 in the same cycle that exec_start is high, and a byte written in that cycle starts the next command.
- R6: Opcode 01000 returns two bytes, exec_res[7:0] (ST0) and then exec_res[15:8] (cylinder). Opcode 00100 returns one byte, exec_res[7:0] (ST3).
- R7: Opcode 10000 returns the single byte 90h. Any opcode outside the lists in R2 returns the single byte 80h (ST0 code 10, invalid). Neither raises exec_start.
- R8: The read of the last result byte returns the status byte to ready, direction 0, bit 4 low.
- R9: These have no effect on the byte counters:
  - a write during the wait for execution or during the result phase;
  - a read during the command phase.

  The command still needs its full byte count, and the result sequence resumes where it was.
- R10: Status bit 5 follows bit 0 of the third byte of the last 00011 command (0 after reset). Bits 3:0 equal drive_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe for the data port |
| wr_data | input | 8 | Byte written by the CPU |
| rd_en | input | 1 | CPU read strobe for the data port |
| rd_data | output | 8 | Current result byte; 00h outside the result phase |
| msr | output | 8 | Main status byte |
| drive_busy | input | 4 | Per-drive seek-busy flags |
| exec_start | output | 1 | One-cycle request to the execution unit |
| exec_op | output | 5 | Opcode of the started command |
| exec_cmd | output | 72 | Command bytes, byte k at [8k+7:8k] |
| exec_done | input | 1 | Execution complete, results valid |
| exec_res | input | 56 | Result bytes from the execution unit, byte k at [8k+7:8k] |

## Verification
The risky overlap is the start pulse of a command that has no result phase and the acceptance of the next command's first byte, which both happen in the same cycle. The bench finishes a seek and writes a sense-interrupt opcode on the very next clock. It then checks three things:

- in the overlap cycle, exec_op and exec_cmd still describe the seek;
- one cycle later, the new opcode is being started;
- the two result bytes that follow come from the second command only.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_e;

  typedef struct packed {
    logic       known;   // opcode recognised
    logic       run;     // needs the execution unit
    logic [3:0] n_cmd;   // total command bytes
    logic [2:0] n_res;   // result bytes
  } op_info_t;

  localparam logic [7:0] VERSION_BYTE = 8'h90;
  localparam logic [7:0] INVALID_BYTE = 8'h80;
  localparam logic [4:0] OP_SPECIFY   = 5'b00011;

  function automatic op_info_t mk(input logic k, input logic r,
                                  input logic [3:0] c, input logic [2:0] s);
    op_info_t i;
    i.known = k;
    i.run   = r;
    i.n_cmd = c;
    i.n_res = s;
    return i;
  endfunction

  function automatic op_info_t lookup(input logic [4:0] op);
    case (op)
      5'b00110, 5'b01100, 5'b00101, 5'b01001,
      5'b00010, 5'b10001, 5'b11001, 5'b11101: return mk(1'b1, 1'b1, 4'd9, 3'd7);
      5'b01010: return mk(1'b1, 1'b1, 4'd2, 3'd7);
      5'b01101: return mk(1'b1, 1'b1, 4'd6, 3'd7);
      5'b00111: return mk(1'b1, 1'b1, 4'd2, 3'd0);
      5'b01000: return mk(1'b1, 1'b1, 4'd1, 3'd2);
      5'b00011: return mk(1'b1, 1'b1, 4'd3, 3'd0);
      5'b00100: return mk(1'b1, 1'b1, 4'd2, 3'd1);
      5'b01111: return mk(1'b1, 1'b1, 4'd3, 3'd0);
      5'b10000: return mk(1'b1, 1'b0, 4'd1, 3'd1);
      default:  return mk(1'b0, 1'b0, 4'd1, 3'd1);
    endcase
  endfunction

endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode
  import fdc_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] first_byte,
  output logic [4:0]    op,
  output op_info_t      info
);
  assign op   = first_byte[4:0];
  assign info = lookup(op);
endmodule

// File: rtl/fdc_cmd_collect.sv
module fdc_cmd_collect #(
  parameter int DW      = 8,
  parameter int MAX_CMD = 9,
  localparam int CNT_W  = $clog2(MAX_CMD + 1),
  localparam int BUF_W  = MAX_CMD * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [DW-1:0]    din,
  input  logic [3:0]       n_cmd,
  output logic [DW-1:0]    first_byte,
  output logic [CNT_W-1:0] cnt,
  output logic             complete,
  output logic [BUF_W-1:0] next_buf
);
  logic [BUF_W-1:0] buf_q;

  always_comb begin
    next_buf = buf_q;
    next_buf[cnt*DW +: DW] = din;
  end

  assign first_byte = (cnt == '0) ? din : buf_q[DW-1:0];
  assign complete   = accept && ((cnt + CNT_W'(1)) == CNT_W'(n_cmd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt   <= '0;
    end else if (accept) begin
      buf_q <= next_buf;
      cnt   <= complete ? '0 : cnt + CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(MAX_CMD)); // R2
endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf #(
  parameter int DW      = 8,
  parameter int MAX_RES = 7,
  localparam int RES_W  = $clog2(MAX_RES + 1),
  localparam int RBITS  = MAX_RES * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] load_len,
  input  logic [RBITS-1:0] load_data,
  input  logic             adv,
  output logic [DW-1:0]    dout,
  output logic             last
);
  logic [RBITS-1:0] data_q;
  logic [RES_W-1:0] len_q;
  logic [RES_W-1:0] idx_q;

  assign dout = data_q[idx_q*DW +: DW];
  assign last = (idx_q + RES_W'(1)) == len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (load) begin
      data_q <= load_data;
      len_q  <= load_len;
      idx_q  <= '0;
    end else if (adv && !last) begin
      idx_q  <= idx_q + RES_W'(1);
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (idx_q < len_q)); // R4
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int MAX_CMD  = 9,
  parameter int MAX_RES  = 7,
  parameter int N_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [DW-1:0]         wr_data,
  input  logic                  rd_en,
  output logic [DW-1:0]         rd_data,
  output logic [7:0]            msr,
  input  logic [N_DRIVES-1:0]   drive_busy,
  output logic                  exec_start,
  output logic [4:0]            exec_op,
  output logic [MAX_CMD*DW-1:0] exec_cmd,
  input  logic                  exec_done,
  input  logic [MAX_RES*DW-1:0] exec_res
);
  localparam int CNT_W = $clog2(MAX_CMD + 1);
  localparam int RES_W = $clog2(MAX_RES + 1);
  localparam int BUF_W = MAX_CMD * DW;
  localparam int RBITS = MAX_RES * DW;

  phase_e           phase;
  logic             nd_q;
  logic [RES_W-1:0] pend_len;

  // named internal events
  logic             cmd_accept;
  logic             cmd_complete;
  logic             res_load;
  logic             res_finish;
  logic             res_last;

  logic [DW-1:0]    first_byte;
  logic [CNT_W-1:0] cnt;
  logic [BUF_W-1:0] next_buf;
  logic [4:0]       op;
  op_info_t         info;
  logic [RES_W-1:0] load_len;
  logic [RBITS-1:0] load_data;
  logic [DW-1:0]    res_byte;

  assign cmd_accept = wr_en && (phase == PH_CMD);

  fdc_cmd_collect #(.DW(DW), .MAX_CMD(MAX_CMD)) u_collect (
    .clk(clk), .rst_n(rst_n), .accept(cmd_accept), .din(wr_data),
    .n_cmd(info.n_cmd), .first_byte(first_byte), .cnt(cnt),
    .complete(cmd_complete), .next_buf(next_buf)
  );

  fdc_op_decode #(.DW(DW)) u_decode (
    .first_byte(first_byte), .op(op), .info(info)
  );

  always_comb begin
    if (phase == PH_EXEC) begin
      res_load  = exec_done;
      load_len  = pend_len;
      load_data = exec_res;
    end else begin
      res_load  = cmd_complete && !info.run;
      load_len  = RES_W'(1);
      load_data = RBITS'(info.known ? VERSION_BYTE : INVALID_BYTE);
    end
  end

  fdc_result_buf #(.DW(DW), .MAX_RES(MAX_RES)) u_result (
    .clk(clk), .rst_n(rst_n), .load(res_load), .load_len(load_len),
    .load_data(load_data), .adv(rd_en && (phase == PH_RES)),
    .dout(res_byte), .last(res_last)
  );

  assign res_finish = (phase == PH_RES) && rd_en && res_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      nd_q       <= 1'b0;
      pend_len   <= '0;
      exec_start <= 1'b0;
      exec_op    <= '0;
      exec_cmd   <= '0;
    end else begin
      exec_start <= 1'b0;
      case (phase)
        PH_CMD: if (cmd_complete) begin
          if (info.run) begin
            exec_start <= 1'b1;
            exec_op    <= op;
            exec_cmd   <= next_buf;
            pend_len   <= RES_W'(info.n_res);
            if (op == OP_SPECIFY) nd_q <= next_buf[2*DW];
            phase      <= (info.n_res == '0) ? PH_CMD : PH_EXEC;
          end else begin
            phase      <= PH_RES;
          end
        end
        PH_EXEC: if (exec_done) phase <= PH_RES;
        PH_RES:  if (res_finish) phase <= PH_CMD;
        default: phase <= PH_CMD;
      endcase
    end
  end

  assign rd_data = (phase == PH_RES) ? res_byte : '0;

  always_comb begin
    msr      = '0;
    msr[7]   = (phase != PH_EXEC);
    msr[6]   = (phase == PH_RES);
    msr[5]   = nd_q;
    msr[4]   = (phase != PH_CMD) || (cnt != '0);
    msr[N_DRIVES-1:0] = drive_busy;
  end

  AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> $past(wr_en)); // R2
  AST_RESULT_ENTRY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr[6]) |-> (msr[7] && msr[4])); // R4
  AST_RESULT_EXIT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msr[6]) |-> ($past(rd_en) && !msr[4] && msr[7])); // R8
  AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr[6]) |-> ($past(wr_en) || $past(exec_done))); // R9
endmodule

// File: tb/fdc_cmd_seq_bench.sv
module fdc_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [7:0]  msr;
  logic [3:0]  drive_busy = '0;
  logic        exec_start;
  logic [4:0]  exec_op;
  logic [71:0] exec_cmd;
  logic        exec_done = 1'b0;
  logic [55:0] exec_res = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit nd_exp = 1'b0;

  always #5 clk = ~clk;

  fdc_cmd_seq u_fdc_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .msr(msr), .drive_busy(drive_busy),
    .exec_start(exec_start), .exec_op(exec_op), .exec_cmd(exec_cmd),
    .exec_done(exec_done), .exec_res(exec_res)
  );

  task automatic chk(input bit ok, input string req, input logic [71:0] act,
                     input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // bench view of the command set: {cmd_len, res_len, runs}
  function automatic void expect_op(input int op, output int nc, output int nr,
                                    output bit runs);
    runs = 1'b1;
    nr = 7;
    nc = 9;
    if (op == 6 || op == 12 || op == 5 || op == 9 || op == 2 ||
        op == 17 || op == 25 || op == 29) nc = 9;
    else if (op == 10) nc = 2;
    else if (op == 13) nc = 6;
    else if (op == 7 || op == 3 || op == 15) begin
      nr = 0;
      nc = (op == 7) ? 2 : 3;
    end
    else if (op == 8) begin nc = 1; nr = 2; end
    else if (op == 4) begin nc = 2; nr = 1; end
    else begin nc = 1; nr = 1; runs = 1'b0; end
  endfunction

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); v = rd_data; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic done(input logic [55:0] r);
    @(negedge clk); exec_done = 1'b1; exec_res = r;
    @(negedge clk); exec_done = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(msr == 8'h80, "R1 status after reset", 72'(msr), 72'h80);
    chk(exec_start == 1'b0, "R1 start idle", 72'(exec_start), 72'h0);
    chk(rd_data == 8'h00, "R1 read data idle", 72'(rd_data), 72'h0);

    for (int op = 0; op < 32; op++) begin
      int nc, nr;
      bit runs;
      logic [71:0] sent;
      logic [55:0] res;
      expect_op(op, nc, nr, runs);
      drive_busy = 4'(op);
      sent = '0;
      @(negedge clk);
      chk(msr[3:0] == 4'(op), "R10 drive busy pass", 72'(msr[3:0]), 72'(op));
      chk(msr[5] == nd_exp, "R10 nd flag", 72'(msr[5]), 72'(nd_exp));
      for (int i = 0; i < nc; i++) begin
        logic [7:0] b;
        b = (i == 0) ? {3'(op * 3), 5'(op)} : 8'(op * 8 + i);
        sent[8*i +: 8] = b;
        if (i == 1) rd(v);  // stray read in command phase, R9
        wr(b);
        if (i < nc - 1)
          chk(msr[7] && !msr[6] && msr[4] && !exec_start,
              "R2 R3 R9 still collecting", 72'(msr), 72'h90);
      end
      if (runs) begin
        chk(exec_start == 1'b1, "R2 start pulse", 72'(exec_start), 72'h1);
        chk(exec_op == 5'(op), "R2 exec opcode", 72'(exec_op), 72'(op));
        chk((exec_cmd & ((72'h1 << (8 * nc)) - 1)) == sent, "R2 command bytes",
            exec_cmd, sent);
        if (op == 3) nd_exp = sent[16];
        if (nr == 0) begin
          chk(msr[7] && !msr[6] && !msr[4], "R5 ready again", 72'(msr), 72'h80);
        end else begin
          chk(!msr[7] && !msr[6] && msr[4], "R3 waiting", 72'(msr), 72'h10);
          wr(8'hEE);  // ignored while waiting, R9
          chk(!msr[7] && !msr[6] && msr[4] && !exec_start, "R9 write in wait",
              72'(msr), 72'h10);
          for (int k = 0; k < 7; k++) res[8*k +: 8] = 8'(op * 16 + k + 1);
          done(res);
          chk(msr[7] && msr[6] && msr[4], "R4 result phase", 72'(msr), 72'hD0);
          for (int k = 0; k < nr; k++) begin
            if (k == 1) begin
              wr(8'h55);  // ignored in result phase, R9
              chk(rd_data == res[15:8], "R9 write in result", 72'(rd_data),
                  72'(res[15:8]));
            end
            rd(v);
            chk(v == res[8*k +: 8], (nr == 7) ? "R4 result byte" :
                                    "R6 sense result byte", 72'(v),
                72'(res[8*k +: 8]));
          end
          chk(msr[7] && !msr[6] && !msr[4], "R8 idle after results",
              72'(msr), 72'h80);
        end
      end else begin
        chk(exec_start == 1'b0, "R7 no start", 72'(exec_start), 72'h0);
        chk(msr[7] && msr[6], "R7 result phase", 72'(msr), 72'hC0);
        rd(v);
        chk(v == ((op == 16) ? 8'h90 : 8'h80), "R7 fixed result", 72'(v),
            72'((op == 16) ? 8'h90 : 8'h80));
        chk(msr[7] && !msr[6] && !msr[4], "R8 idle after fixed",
            72'(msr), 72'h80);
      end
    end

    // specify with the non-DMA bit set and then cleared, R10
    drive_busy = '0;
    wr(8'h03); wr(8'hAF); wr(8'h03);
    @(negedge clk);
    chk(msr[5] == 1'b1, "R10 nd set", 72'(msr[5]), 72'h1);
    wr(8'h03); wr(8'hAF); wr(8'h02);
    @(negedge clk);
    chk(msr[5] == 1'b0, "R10 nd clear", 72'(msr[5]), 72'h0);

    // seek followed at once by sense interrupt, R5 and R6
    wr(8'h0F); wr(8'h01);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h22;
    @(negedge clk); wr_data = 8'h08;
    chk(exec_start && exec_op == 5'h0F, "R5 seek start", 72'(exec_op), 72'h0F);
    chk(exec_cmd[23:0] == 24'h22010F, "R5 seek bytes", 72'(exec_cmd[23:0]),
        72'h22010F);
    chk(msr[7] && !msr[6], "R5 ready in start cycle", 72'(msr), 72'h80);
    @(negedge clk); wr_en = 1'b0;
    chk(exec_start && exec_op == 5'h08, "R5 next command started",
        72'(exec_op), 72'h08);
    chk(!msr[7] && msr[4], "R3 waiting after overlap", 72'(msr), 72'h10);
    done(56'h0000_0000_0033_20);
    rd(v);
    chk(v == 8'h20, "R6 sense ST0", 72'(v), 72'h20);
    rd(v);
    chk(v == 8'h33, "R6 sense cylinder", 72'(v), 72'h33);
    chk(msr[7] && !msr[6] && !msr[4], "R8 idle after sense", 72'(msr), 72'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule